// File: doc/BRIEF.md
# March C- Memory Self-Test Sequencer

This block is a self-test engine for a bit-wide memory array. After a one-cycle start pulse it walks the whole address space through the six March C- elements. It drives the address, the write strobe and the write bit, and it checks every read against the value that element expects. The address order is ascending for the first three elements and descending for the last three. Within each element a read comes before the write at the same address.

Read data returns one cycle after the read address is presented. The engine therefore compares against a copy of the expected bit that is delayed by one cycle. When the walk ends it raises a completion flag and gives a pass or fail verdict. For diagnosis it also reports the address of the first failing read and a saturating count of failing reads. A new start pulse after completion clears the results and repeats the test from the first element.

Top module: `mtest_seq`

## Requirements
- R1: After reset, done, go, nogo and we are 0, and fail_addr and err_count are 0.
- R2: A start pulse sampled while idle begins the first element in the next cycle. That element writes 0 to every address, one address per cycle, from address 0 up to 2^AW-1.
- R3: The second and third elements run in ascending address order and use two cycles per address: a read (we=0), then a write (we=1). The write bit is 1 in the second element and 0 in the third.
- R4: The fourth and fifth elements run in descending address order, from 2^AW-1 down to 0, with the same read-then-write pair. The write bit is 1 in the fourth element and 0 in the fifth.
- R5: The sixth element reads each address once in descending order. The run takes exactly 10·2^AW memory cycles, and done rises one cycle after the last read cycle.
- R6: rdata is sampled one cycle after the read address. Reads expect 0 in elements two, four and six and 1 in elements three and five. Any mismatch sets nogo, and nogo stays set until the next accepted start.
- R7: fail_addr holds the address of the first mismatching read of the run. Later mismatches do not change it.
- R8: err_count increases by one for each mismatching read and saturates at 2^CW-1.
- R9: While done is 1, go equals the inverse of nogo. While done is 0, go is 0.
- R10: A start pulse that arrives while a run is in progress is ignored. The operation stream and the completion time do not change.
- R11: A start accepted after done clears done, nogo, fail_addr and err_count, and the test begins again at the first element.
- R12: we is 0 whenever no run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| addr | output | AW | Memory address |
| we | output | 1 | Write strobe (1 = write, 0 = read) |
| wdata | output | 1 | Write bit |
| rdata | input | 1 | Read bit, valid one cycle after a read address |
| go | output | 1 | Pass verdict, valid with done |
| nogo | output | 1 | Sticky fail flag |
| done | output | 1 | Run complete |
| fail_addr | output | AW | Address of the first failing read |
| err_count | output | CW | Saturating count of failing reads |

## Verification
A wrong element or address state appears on addr, we or wdata in the same cycle it occurs, so the bench compares the operation stream against an arithmetic schedule on every cycle of the run. Errors in the compare pipeline, such as misaligned expected data, a non-sticky flag or an overwritten failure address, do not appear until done. They show up as a wrong error count or fail_addr for stuck-at patterns whose failing reads the bench counts per element. A sequencer that stalls or skips shows up as done arriving in the wrong cycle, and the bench checks that cycle exactly.

// File: rtl/mtest_pkg.sv
package mtest_pkg;

  typedef enum logic [2:0] {
    EL_M0 = 3'd0,
    EL_M1 = 3'd1,
    EL_M2 = 3'd2,
    EL_M3 = 3'd3,
    EL_M4 = 3'd4,
    EL_M5 = 3'd5
  } elem_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } seq_state_e;

  // Element walks addresses downward
  function automatic logic elem_down(elem_e e);
    return (e == EL_M3) || (e == EL_M4) || (e == EL_M5);
  endfunction

  // Operations per address in an element
  function automatic logic [1:0] elem_len(elem_e e);
    return ((e == EL_M0) || (e == EL_M5)) ? 2'd1 : 2'd2;
  endfunction

  // Value a read in this element expects
  function automatic logic elem_rd_val(elem_e e);
    return (e == EL_M2) || (e == EL_M4);
  endfunction

  // Value a write in this element stores
  function automatic logic elem_wr_val(elem_e e);
    return (e == EL_M1) || (e == EL_M3);
  endfunction

  // Slot op of element e is a read
  function automatic logic op_reads(elem_e e, logic op);
    return (e != EL_M0) && (op == 1'b0);
  endfunction

  // Following element; after M5 the run ends
  function automatic elem_e elem_next(elem_e e);
    return elem_e'(3'(e) + 3'd1);
  endfunction

  // Saturating increment
  function automatic logic [15:0] sat_inc(logic [15:0] v, logic [15:0] lim);
    return (v >= lim) ? lim : v + 16'd1;
  endfunction

endpackage

// File: rtl/mtest_addr_gen.sv
module mtest_addr_gen #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic          step_up,
  input  logic          step_dn,
  output logic [AW-1:0] addr,
  output logic          at_top,
  output logic          at_bot
);
  localparam logic [AW-1:0] TOP = {AW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (ld_lo)   addr <= '0;
    else if (ld_hi)   addr <= TOP;
    else if (step_up) addr <= addr + 1'b1;
    else if (step_dn) addr <= addr - 1'b1;
  end

  assign at_top = (addr == TOP);
  assign at_bot = (addr == '0);
endmodule

// File: rtl/mtest_elem_seq.sv
module mtest_elem_seq
  import mtest_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  logic  at_top,
  input  logic  at_bot,
  output logic  start_acc,
  output logic  running,
  output logic  we,
  output logic  wdata,
  output logic  rd_now,
  output logic  exp_now,
  output logic  ld_lo,
  output logic  ld_hi,
  output logic  step_up,
  output logic  step_dn,
  output logic  finish,
  output elem_e elem
);
  seq_state_e st;
  logic       op;
  logic       last_op;
  logic       end_addr;
  logic       elem_done;

  always_comb begin
    start_acc = start && (st == ST_IDLE);
    running   = (st == ST_RUN);
    finish    = (st == ST_DRAIN);
    rd_now    = running && op_reads(elem, op);
    we        = running && !op_reads(elem, op);
    wdata     = we && elem_wr_val(elem);
    exp_now   = elem_rd_val(elem);
    last_op   = ({1'b0, op} == (elem_len(elem) - 2'd1));
    end_addr  = elem_down(elem) ? at_bot : at_top;
    elem_done = running && last_op && end_addr;
    ld_lo     = start_acc || (elem_done && ((elem == EL_M0) || (elem == EL_M1)));
    ld_hi     = elem_done && ((elem == EL_M2) || (elem == EL_M3) || (elem == EL_M4));
    step_up   = running && last_op && !end_addr && !elem_down(elem);
    step_dn   = running && last_op && !end_addr && elem_down(elem);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      elem <= EL_M0;
      op   <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (start_acc) begin
          st   <= ST_RUN;
          elem <= EL_M0;
          op   <= 1'b0;
        end
        ST_RUN: begin
          if (last_op) begin
            op <= 1'b0;
            if (end_addr) begin
              if (elem == EL_M5) st <= ST_DRAIN;
              else               elem <= elem_next(elem);
            end
          end else begin
            op <= 1'b1;
          end
        end
        ST_DRAIN: st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mtest_cmp.sv
module mtest_cmp
  import mtest_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          rd_now,
  input  logic          exp_now,
  input  logic [AW-1:0] addr,
  input  logic          rdata,
  input  logic          finish,
  output logic          mismatch,
  output logic          nogo,
  output logic          go,
  output logic          done,
  output logic [AW-1:0] fail_addr,
  output logic [CW-1:0] err_count
);
  localparam logic [15:0] ERR_MAX = 16'((1 << CW) - 1);

  logic          rd_q;
  logic          exp_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      rd_q   <= rd_now && !clear;
      exp_q  <= exp_now;
      addr_q <= addr;
    end
  end

  assign mismatch = rd_q && (rdata != exp_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nogo      <= 1'b0;
      done      <= 1'b0;
      fail_addr <= '0;
      err_count <= '0;
    end else if (clear) begin
      nogo      <= 1'b0;
      done      <= 1'b0;
      fail_addr <= '0;
      err_count <= '0;
    end else begin
      if (mismatch) begin
        nogo      <= 1'b1;
        err_count <= CW'(sat_inc(16'(err_count), ERR_MAX));
        if (!nogo) fail_addr <= addr_q;
      end
      if (finish) done <= 1'b1;
    end
  end

  assign go = done && !nogo;
endmodule

// File: rtl/mtest_seq.sv
module mtest_seq
  import mtest_pkg::*;
#(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic          wdata,
  input  logic          rdata,
  output logic          go,
  output logic          nogo,
  output logic          done,
  output logic [AW-1:0] fail_addr,
  output logic [CW-1:0] err_count
);
  logic  start_acc;
  logic  running;
  logic  rd_now;
  logic  exp_now;
  logic  ld_lo;
  logic  ld_hi;
  logic  step_up;
  logic  step_dn;
  logic  finish;
  logic  at_top;
  logic  at_bot;
  logic  mismatch;
  elem_e elem;

  mtest_addr_gen #(.AW(AW)) addr_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_lo   (ld_lo),
    .ld_hi   (ld_hi),
    .step_up (step_up),
    .step_dn (step_dn),
    .addr    (addr),
    .at_top  (at_top),
    .at_bot  (at_bot)
  );

  mtest_elem_seq seq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .at_top    (at_top),
    .at_bot    (at_bot),
    .start_acc (start_acc),
    .running   (running),
    .we        (we),
    .wdata     (wdata),
    .rd_now    (rd_now),
    .exp_now   (exp_now),
    .ld_lo     (ld_lo),
    .ld_hi     (ld_hi),
    .step_up   (step_up),
    .step_dn   (step_dn),
    .finish    (finish),
    .elem      (elem)
  );

  mtest_cmp #(.AW(AW), .CW(CW)) cmp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (start_acc),
    .rd_now    (rd_now),
    .exp_now   (exp_now),
    .addr      (addr),
    .rdata     (rdata),
    .finish    (finish),
    .mismatch  (mismatch),
    .nogo      (nogo),
    .go        (go),
    .done      (done),
    .fail_addr (fail_addr),
    .err_count (err_count)
  );
endmodule

// File: rtl/mtest_seq_chk.sv
module mtest_seq_chk #(
  parameter int AW = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_acc,
  input logic          running,
  input logic          mismatch,
  input logic          we,
  input logic          go,
  input logic          nogo,
  input logic          done,
  input logic [AW-1:0] fail_addr,
  input logic [CW-1:0] err_count
);
  localparam logic [CW-1:0] ERR_MAX = {CW{1'b1}};

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !we); // R12
  AST_DONE_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !running); // R5
  AST_GO_NOT_NOGO: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && nogo)); // R9
  AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    mismatch |=> nogo); // R6
  AST_NOGO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nogo && !start_acc) |=> nogo); // R6
  AST_FIRST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nogo && !start_acc) |=> $stable(fail_addr)); // R7
  AST_ERR_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == ERR_MAX) && !start_acc) |=> (err_count == ERR_MAX)); // R8
  AST_ERR_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    !start_acc |=> (err_count >= $past(err_count))); // R8
  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (!done && !nogo && (err_count == '0))); // R11
endmodule

bind mtest_seq mtest_seq_chk #(.AW(AW), .CW(CW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start_acc (start_acc),
  .running   (running),
  .mismatch  (mismatch),
  .we        (we),
  .go        (go),
  .nogo      (nogo),
  .done      (done),
  .fail_addr (fail_addr),
  .err_count (err_count)
);

// File: tb/mtest_seq_tb_top.sv
`timescale 1ns/1ps
module mtest_seq_tb_top;
  localparam int AW  = 4;
  localparam int CW  = 4;
  localparam int N   = 1 << AW;
  localparam int OPS = 10 * N;
  localparam int EMX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr;
  logic          we;
  logic          wdata;
  logic          rdata;
  logic          go;
  logic          nogo;
  logic          done;
  logic [AW-1:0] fail_addr;
  logic [CW-1:0] err_count;

  logic          mem [N];
  logic [N-1:0]  s0 = '0;
  logic [N-1:0]  s1 = '0;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  mtest_seq #(.AW(AW), .CW(CW)) dut_i (
    .clk (clk), .rst_n (rst_n), .start (start),
    .addr (addr), .we (we), .wdata (wdata), .rdata (rdata),
    .go (go), .nogo (nogo), .done (done),
    .fail_addr (fail_addr), .err_count (err_count)
  );

  // behavioural array with stuck-at faults applied on read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= (mem[addr] | s1[addr]) & ~s0[addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one full run with the op stream compared every cycle
  task automatic run_march(input bit poke);
    int m0b = 0, ab = 0, db = 0, m5b = 0, early = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int c = 0; c < OPS; c++) begin
      logic [AW-1:0] ea;
      bit ewe, ewd, miss;
      int grp;
      if (poke && c == 37) start = 1'b1;
      if (poke && c == 38) start = 1'b0;
      if (c < N) begin
        ea = AW'(c); ewe = 1; ewd = 0; grp = 0;
      end else if (c < 9 * N) begin
        int k = c - N;
        int e = k / (2 * N) + 1;
        int r = k % (2 * N);
        ea  = (e <= 2) ? AW'(r / 2) : AW'(N - 1 - r / 2);
        ewe = (r % 2) == 1;
        ewd = (e == 1) || (e == 3);
        grp = (e <= 2) ? 1 : 2;
      end else begin
        ea = AW'(N - 1 - (c - 9 * N)); ewe = 0; ewd = 0; grp = 3;
      end
      miss = (addr != ea) || (we != ewe) || (ewe && (wdata != ewd));
      if (miss) begin
        case (grp)
          0: m0b++;
          1: ab++;
          2: db++;
          default: m5b++;
        endcase
      end
      if (done) early++;
      @(negedge clk);
    end
    if (done) early++;
    @(negedge clk);
    chk(m0b == 0, "R2 first element writes 0 ascending", m0b, 0);
    chk(ab == 0, "R3 ascending read/write elements", ab, 0);
    chk(db == 0, "R4 descending read/write elements", db, 0);
    chk(m5b == 0, "R5 final descending reads", m5b, 0);
    chk(early == 0 && done, "R5 done exactly 10N+1 cycles after start", int'(done), 1);
    if (poke) chk(early == 0 && done, "R10 mid-run start ignored", early, 0);
    chk(we == 1'b0, "R12 no write after completion", int'(we), 0);
  endtask

  task automatic check_result(input string tag);
    int ones = 0, zeros = 0, exp_err;
    int ef = -1;
    for (int a = N - 1; a >= 0; a--) begin
      if (s1[a]) begin ones++; end
      if (s0[a]) begin zeros++; end
    end
    // M1 ascending hits the lowest stuck-1 first, else M2 the lowest stuck-0
    for (int a = N - 1; a >= 0; a--) if (s0[a]) ef = a;
    for (int a = N - 1; a >= 0; a--) if (s1[a]) ef = a;
    exp_err = 3 * ones + 2 * zeros;
    if (exp_err > EMX) exp_err = EMX;
    chk(nogo == (ef >= 0), {"R6 fail flag ", tag}, int'(nogo), int'(ef >= 0));
    chk(go == (ef < 0), {"R9 verdict ", tag}, int'(go), int'(ef < 0));
    chk(int'(fail_addr) == ((ef < 0) ? 0 : ef), {"R7 first failing address ", tag},
        int'(fail_addr), (ef < 0) ? 0 : ef);
    chk(int'(err_count) == exp_err, {"R8 error count ", tag}, int'(err_count), exp_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!done && !go && !nogo && !we, "R1 reset flags", int'({done, go, nogo, we}), 0);
    chk(fail_addr == '0 && err_count == '0, "R1 reset results",
        int'(fail_addr) + int'(err_count), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!we && !done, "R12 idle with no write", int'(we), 0);

    run_march(1'b0);
    check_result("clean");

    s1 = '0; s0 = '0; s1[5] = 1'b1;
    run_march(1'b0);
    check_result("stuck1@5");
    chk(nogo && done, "R11 results still held before restart", int'(nogo), 1);

    s1 = '0; s0 = '0; s0[N-1] = 1'b1;
    run_march(1'b0);
    check_result("stuck0@top");

    s1 = '0; s0 = '0; s0[2] = 1'b1; s1[11] = 1'b1;
    run_march(1'b0);
    check_result("mixed");

    s1 = '0; s0 = '0; s0[12] = 1'b1; s0[3] = 1'b1;
    run_march(1'b0);
    check_result("two stuck0");

    s1 = '0; s0 = '0; s1[5:0] = '1;
    run_march(1'b1);
    check_result("saturate");

    s1 = '0; s0 = '0;
    run_march(1'b1);
    check_result("R11 restart clears");

    repeat (4) @(negedge clk);
    chk(done && go, "R9 done and go held while idle", int'(go), 1);
    summary();
  end
endmodule